// File: doc/BRIEF.md
# ADC Multiplexer Frame Sequencer

This block sets the pace for a shared analog-to-digital converter that serves up to four input channels. It advances on a slow sample-clock enable (`slowTick`) inside a fast clock domain. The nominal ratio is 150 fast cycles per slow cycle, but the block works for any spacing between ticks. Each frame converts channels in ascending order, starting at channel 0. Every conversion lasts two or three slow cycles, depending on the filter-length select. The frame ends with one settle cycle, which lets the reference recover before the next frame begins.

At the start of each frame the block emits a one-cycle frame-sync pulse. This marks the start of a compute pass. A compute-busy flag is then held for a programmable number of fast cycles. When a conversion ends, the block issues a write strobe and a memory address so the result can be stored. A pass counter raises a transfer-busy flag for one whole frame once every `presamps * sumCycles` passes.

The frame settings are captured at the start of each frame, so a change made mid-frame takes effect at the next frame.

Top module: `adc_mux_sequencer`

## Requirements
- R1: With `longFilter`=0, every conversion lasts 2 slow ticks, so a frame lasts 1 + 2*N slow ticks, where N is the effective conversion count. Frame length is counted from one `frameSync` pulse to the next.
- R2: With `longFilter`=1, every conversion lasts 3 slow ticks, so a frame lasts 1 + 3*N slow ticks.
- R3: Within a frame, `chanSel` takes the values 0, 1, …, N-1 in that order. After the last conversion, `settle` is 1 for exactly one slow tick. During settle, `chanSel` keeps the last channel.
- R4: The effective conversion count N follows `muxDiv` as follows:
  - `muxDiv` = 0 gives N = 1.
  - `muxDiv` = 1 to 3 gives N = `muxDiv`.
  - `muxDiv` of 4 or more gives N = 4.
- R5: `frameSync` is high for exactly one fast cycle. It is driven by the fast-clock edge that samples `slowTick` while `settle` is 1. In that same cycle `chanSel` is 0 and `settle` is 0.
- R6: `wrEn` is high for one fast cycle on the edge that samples the final tick of a conversion, and `wrAddr` = `ADDR_BASE` + that channel number. It never coincides with `frameSync`.
- R7: `busy` goes high in the cycle of `frameSync` and stays high for exactly `busyLen` fast cycles. A `busyLen` of 0 leaves `busy` low.
- R8: `xferBusy` stays high for the whole frame, from one `frameSync` to the next, once every `presamps*sumCycles` frames, and the pass counter then restarts. A product of 0 or 1 raises it on every frame.
- R9: The `muxDiv`, `longFilter`, pass-count and `busyLen` settings are sampled only at a frame start. Changes made mid-frame do not alter the current frame.
- R10: During reset:
  - `settle` = 1 and `chanSel` = 0;
  - `frameSync`, `wrEn`, `busy` and `xferBusy` are 0.
  
  The first `slowTick` after reset starts a frame.
- R11: Without `slowTick`, `chanSel` and `settle` hold their values and no `frameSync` or `wrEn` occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | One-cycle slow sample-clock enable |
| muxDiv | input | DIV_W | Conversions per frame (0→1, ≥4→4) |
| longFilter | input | 1 | 1: three slow ticks per conversion, 0: two |
| presamps | input | PS_W | Pass-count factor A |
| sumCycles | input | SC_W | Pass-count factor B |
| busyLen | input | BUSY_W | Fast cycles of compute busy per frame |
| chanSel | output | 2 | Channel currently converted |
| settle | output | 1 | Settle (reference recovery) state |
| frameSync | output | 1 | Frame / compute-pass start pulse |
| busy | output | 1 | Compute busy |
| wrEn | output | 1 | Conversion result write strobe |
| wrAddr | output | ADDR_W | Data memory address for the result |
| xferBusy | output | 1 | Transfer busy, one frame per pass period |

## Verification
The hardest situation to reach is a configuration change that lands mid-frame at the same moment as a pass-count wrap or a busy window that has not yet expired. It takes many frames under varied settings before these coincide.

The stimulus changes every setting at random instants, not at frame boundaries, and varies the spacing between slow ticks, including back-to-back ticks. A cycle-accurate bench model compares every output on every fast cycle. Directed runs then measure exact frame lengths for the extreme `muxDiv` values, the deferred effect of a mid-frame change, and a transfer period of six passes.

// File: rtl/adc_mux_seq_pkg.sv
package adc_mux_seq_pkg;
  localparam int unsigned SEQ_MAX_CONV = 4;
  localparam int unsigned SEQ_CHAN_W   = $clog2(SEQ_MAX_CONV);

  typedef struct packed {
    logic                  frameStart;
    logic                  convDone;
    logic [SEQ_CHAN_W-1:0] doneChan;
  } seq_strobe_t;
endpackage

// File: rtl/adc_mux_frame_ctrl.sv
module adc_mux_frame_ctrl
  import adc_mux_seq_pkg::*;
#(
  parameter int unsigned DIV_W     = 3,
  parameter int unsigned SHORT_LEN = 2,
  parameter int unsigned LONG_LEN  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  slowTick,
  input  logic [DIV_W-1:0]      muxDiv,
  input  logic                  longFilter,
  output logic [SEQ_CHAN_W-1:0] chanSel,
  output logic                  settle,
  output seq_strobe_t           strobes
);
  localparam int unsigned SUB_W = (LONG_LEN > SHORT_LEN) ? $clog2(LONG_LEN) : $clog2(SHORT_LEN);
  localparam logic [SUB_W-1:0] SHORT_LAST = SUB_W'(SHORT_LEN - 1);
  localparam logic [SUB_W-1:0] LONG_LAST  = SUB_W'(LONG_LEN - 1);

  logic                  settleQ;
  logic [SEQ_CHAN_W-1:0] chanQ;
  logic [SUB_W-1:0]      subQ;
  logic [SEQ_CHAN_W-1:0] lastChanQ;
  logic [SUB_W-1:0]      lastSubQ;
  logic [SEQ_CHAN_W-1:0] effLast;
  logic                  frameStart;
  logic                  convDone;

  // Clamp the requested conversion count into 1..SEQ_MAX_CONV.
  always_comb begin
    if (muxDiv == '0)
      effLast = '0;
    else if (32'(muxDiv) >= SEQ_MAX_CONV)
      effLast = SEQ_CHAN_W'(SEQ_MAX_CONV - 1);
    else
      effLast = SEQ_CHAN_W'(32'(muxDiv) - 1);
  end

  assign frameStart = slowTick && settleQ;
  assign convDone   = slowTick && !settleQ && (subQ == lastSubQ);

  always_comb begin
    strobes.frameStart = frameStart;
    strobes.convDone   = convDone;
    strobes.doneChan   = chanQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      settleQ   <= 1'b1;
      chanQ     <= '0;
      subQ      <= '0;
      lastChanQ <= '0;
      lastSubQ  <= SHORT_LAST;
    end else if (frameStart) begin
      settleQ   <= 1'b0;
      chanQ     <= '0;
      subQ      <= '0;
      lastChanQ <= effLast;
      lastSubQ  <= longFilter ? LONG_LAST : SHORT_LAST;
    end else if (convDone) begin
      subQ <= '0;
      if (chanQ == lastChanQ)
        settleQ <= 1'b1;
      else
        chanQ <= chanQ + 1'b1;
    end else if (slowTick && !settleQ) begin
      subQ <= subQ + 1'b1;
    end
  end

  assign chanSel = chanQ;
  assign settle  = settleQ;
endmodule

// File: rtl/adc_mux_frame_dp.sv
module adc_mux_frame_dp
  import adc_mux_seq_pkg::*;
#(
  parameter int unsigned PS_W      = 8,
  parameter int unsigned SC_W      = 8,
  parameter int unsigned BUSY_W    = 8,
  parameter int unsigned ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 6'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobes,
  input  logic [PS_W-1:0]   presamps,
  input  logic [SC_W-1:0]   sumCycles,
  input  logic [BUSY_W-1:0] busyLen,
  output logic              frameSync,
  output logic              busy,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              xferBusy
);
  localparam int unsigned PASS_W = PS_W + SC_W;

  logic [BUSY_W-1:0] busyQ;
  logic [PASS_W-1:0] passQ;
  logic [PASS_W:0]   passTarget;
  logic [PASS_W:0]   passNext;
  logic              passWrap;
  logic [ADDR_W-1:0] addrD;

  // Address forming: concatenate when the base is aligned, add otherwise.
  generate
    if ((ADDR_BASE % (1 << SEQ_CHAN_W)) == 0) begin : g_addr_cat
      assign addrD = {ADDR_BASE[ADDR_W-1:SEQ_CHAN_W], strobes.doneChan};
    end else begin : g_addr_add
      assign addrD = ADDR_BASE + ADDR_W'(strobes.doneChan);
    end
  endgenerate

  assign passTarget = (PASS_W+1)'(presamps * sumCycles);
  assign passNext   = {1'b0, passQ} + 1'b1;
  assign passWrap   = passNext >= passTarget;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameSync <= 1'b0;
      wrEn      <= 1'b0;
      wrAddr    <= '0;
      busyQ     <= '0;
      passQ     <= '0;
      xferBusy  <= 1'b0;
    end else begin
      frameSync <= strobes.frameStart;
      wrEn      <= strobes.convDone;
      if (strobes.convDone)
        wrAddr <= addrD;
      if (strobes.frameStart)
        busyQ <= busyLen;
      else if (busyQ != '0)
        busyQ <= busyQ - 1'b1;
      if (strobes.frameStart) begin
        if (passWrap) begin
          passQ    <= '0;
          xferBusy <= 1'b1;
        end else begin
          passQ    <= passNext[PASS_W-1:0];
          xferBusy <= 1'b0;
        end
      end
    end
  end

  assign busy = busyQ != '0;
endmodule

// File: rtl/adc_mux_sequencer.sv
module adc_mux_sequencer
  import adc_mux_seq_pkg::*;
#(
  parameter int unsigned DIV_W     = 3,
  parameter int unsigned PS_W      = 8,
  parameter int unsigned SC_W      = 8,
  parameter int unsigned BUSY_W    = 8,
  parameter int unsigned ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 6'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic [DIV_W-1:0]  muxDiv,
  input  logic              longFilter,
  input  logic [PS_W-1:0]   presamps,
  input  logic [SC_W-1:0]   sumCycles,
  input  logic [BUSY_W-1:0] busyLen,
  output logic [1:0]        chanSel,
  output logic              settle,
  output logic              frameSync,
  output logic              busy,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              xferBusy
);
  seq_strobe_t strobes;

  adc_mux_frame_ctrl #(
    .DIV_W(DIV_W), .SHORT_LEN(2), .LONG_LEN(3)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .muxDiv(muxDiv),
    .longFilter(longFilter), .chanSel(chanSel), .settle(settle),
    .strobes(strobes)
  );

  adc_mux_frame_dp #(
    .PS_W(PS_W), .SC_W(SC_W), .BUSY_W(BUSY_W), .ADDR_W(ADDR_W), .ADDR_BASE(ADDR_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .presamps(presamps),
    .sumCycles(sumCycles), .busyLen(busyLen), .frameSync(frameSync),
    .busy(busy), .wrEn(wrEn), .wrAddr(wrAddr), .xferBusy(xferBusy)
  );
endmodule

// File: rtl/adc_mux_sequencer_checker.sv
module adc_mux_sequencer_checker (
  input logic       clk,
  input logic       rstN,
  input logic       slowTick,
  input logic [1:0] chanSel,
  input logic       settle,
  input logic       frameSync,
  input logic       busy,
  input logic       wrEn
);
  p_sync_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> !frameSync);
  p_sync_chan0_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> (chanSel == 2'd0) && !settle);
  p_sync_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> $past(slowTick) && $past(settle));
  p_settle_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (settle && slowTick) |=> !settle);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !slowTick |=> $stable(chanSel) && $stable(settle) && !frameSync && !wrEn);
  p_wr_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(slowTick) && !frameSync);
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> frameSync);
endmodule

bind adc_mux_sequencer adc_mux_sequencer_checker u_checker (
  .clk(clk), .rstN(rstN), .slowTick(slowTick), .chanSel(chanSel),
  .settle(settle), .frameSync(frameSync), .busy(busy), .wrEn(wrEn)
);

// File: tb/adc_mux_sequencer_bench.sv
module adc_mux_sequencer_bench;
  localparam logic [5:0] BASE = 6'h10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       slowTick = 1'b0;
  logic [2:0] muxDiv = 3'd4;
  logic       longFilter = 1'b0;
  logic [7:0] presamps = 8'd1;
  logic [7:0] sumCycles = 8'd1;
  logic [7:0] busyLen = 8'd3;
  logic [1:0] chanSel;
  logic       settle, frameSync, busy, wrEn, xferBusy;
  logic [5:0] wrAddr;

  int checks = 0, errors = 0;
  bit done = 0;
  int gap = 2;
  // bench model state
  bit mSettle = 1, mSync = 0, mWr = 0, mXfer = 0;
  int mChan = 0, mSub = 0, mLast = 0, mLen = 2, mBusy = 0, mPass = 0, mAddr = 0;
  int ticksSince = 0, lastLen = 0, frames = 0, xferFrames = 0;

  always #2 clk = ~clk;

  adc_mux_sequencer u_adc_mux_sequencer (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .muxDiv(muxDiv),
    .longFilter(longFilter), .presamps(presamps), .sumCycles(sumCycles),
    .busyLen(busyLen), .chanSel(chanSel), .settle(settle),
    .frameSync(frameSync), .busy(busy), .wrEn(wrEn), .wrAddr(wrAddr),
    .xferBusy(xferBusy)
  );

  function automatic int effLast(input int d);
    if (d == 0) return 0;
    if (d >= 4) return 3;
    return d - 1;
  endfunction

  function automatic int expFrame(input int d, input bit lf);
    return 1 + (effLast(d) + 1) * (lf ? 3 : 2);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit t);
    slowTick = t;
    @(posedge clk);
    if (rstN) begin
      mSync = 0; mWr = 0;
      if (mBusy != 0) mBusy--;
      if (t) begin
        if (mSettle) begin
          mSettle = 0; mChan = 0; mSub = 0;
          mLast = effLast(int'(muxDiv)); mLen = longFilter ? 3 : 2;
          mSync = 1; mBusy = int'(busyLen);
          if (mPass + 1 >= int'(presamps) * int'(sumCycles)) begin mPass = 0; mXfer = 1; end
          else begin mPass++; mXfer = 0; end
        end else if (mSub == mLen - 1) begin
          mWr = 1; mAddr = int'(BASE) + mChan; mSub = 0;
          if (mChan == mLast) mSettle = 1; else mChan++;
        end else mSub++;
      end
    end
    @(negedge clk);
    if (rstN) begin
      chk(int'(chanSel) == mChan, "R3", "chanSel", chanSel, mChan);
      chk(settle == mSettle, "R3", "settle", settle, mSettle);
      chk(frameSync == mSync, "R5", "frameSync", frameSync, mSync);
      chk(busy == (mBusy != 0), "R7", "busy", busy, mBusy != 0);
      chk(wrEn == mWr, "R6", "wrEn", wrEn, mWr);
      if (mWr) chk(int'(wrAddr) == mAddr, "R6", "wrAddr", wrAddr, mAddr);
      chk(xferBusy == mXfer, "R8", "xferBusy", xferBusy, mXfer);
      if (t) ticksSince++;
      if (frameSync) begin
        lastLen = ticksSince; ticksSince = 0; frames++;
        if (xferBusy) xferFrames++;
      end
    end
  endtask

  task automatic tickGap();
    cyc(1);
    repeat (gap - 1) cyc(0);
  endtask

  task automatic waitSync();
    int f0 = frames;
    while (frames == f0) tickGap();
  endtask

  task automatic frameLen(output int len);
    waitSync();
    waitSync();
    len = lastLen;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int len;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(chanSel == 2'd0 && settle, "R10", "chanSel/settle in reset", {chanSel, settle}, 1);
    chk(!frameSync && !wrEn && !busy && !xferBusy, "R10", "strobes in reset",
        {frameSync, wrEn, busy, xferBusy}, 0);
    rstN = 1'b1;
    cyc(0);
    // R10: first tick after reset starts a frame
    cyc(1);
    chk(frameSync == 1'b1, "R10", "first tick frameSync", frameSync, 1);

    // R1: short filter, four conversions
    gap = 2; muxDiv = 3'd4; longFilter = 1'b0;
    frameLen(len); chk(len == 9, "R1", "frame length short div4", len, 9);
    muxDiv = 3'd3; frameLen(len); chk(len == 7, "R1", "frame length short div3", len, 7);
    // R2: long filter
    longFilter = 1'b1; muxDiv = 3'd2;
    frameLen(len); chk(len == 7, "R2", "frame length long div2", len, 7);
    // R4: clamp of muxDiv
    muxDiv = 3'd0; longFilter = 1'b0;
    frameLen(len); chk(len == 3, "R4", "muxDiv 0 length", len, 3);
    muxDiv = 3'd7; longFilter = 1'b1;
    frameLen(len); chk(len == 13, "R4", "muxDiv 7 length", len, 13);
    // R2 at nominal 150 fast cycles per slow tick
    gap = 150; muxDiv = 3'd4;
    frameLen(len); chk(len == 13, "R2", "frame length at 150 ratio", len, 13);
    gap = 1;
    // R9: mid-frame change deferred
    muxDiv = 3'd2; longFilter = 1'b0;
    waitSync();
    repeat (2) tickGap();
    muxDiv = 3'd4; longFilter = 1'b1;
    waitSync();
    chk(lastLen == 5, "R9", "frame with mid-frame change", lastLen, 5);
    waitSync();
    chk(lastLen == 13, "R9", "next frame uses new setting", lastLen, 13);
    // R8: one transfer frame every six passes
    muxDiv = 3'd1; longFilter = 1'b0; presamps = 8'd2; sumCycles = 8'd3;
    waitSync();
    xferFrames = 0;
    repeat (12) waitSync();
    chk(xferFrames == 2, "R8", "transfer frames in 12 passes", xferFrames, 2);
    presamps = 8'd0;
    xferFrames = 0;
    waitSync(); xferFrames = 0;
    repeat (4) waitSync();
    chk(xferFrames == 4, "R8", "zero product every pass", xferFrames, 4);
    // R7: zero busy length
    busyLen = 8'd0; waitSync(); waitSync();
    chk(!busy, "R7", "busy with zero length", busy, 0);
    // R11: hold without ticks
    begin
      logic [1:0] c0; logic s0; int f0;
      tickGap(); tickGap();
      c0 = chanSel; s0 = settle; f0 = frames;
      repeat (30) cyc(0);
      chk(chanSel == c0 && settle == s0 && frames == f0, "R11", "hold without tick",
          {chanSel, settle}, {c0, s0});
    end
    // random mix, per-cycle model comparison covers R3 R5 R6 R7 R8
    for (int i = 0; i < 400; i++) begin
      muxDiv = 3'($urandom % 8);
      longFilter = 1'($urandom % 2);
      presamps = 8'($urandom % 4);
      sumCycles = 8'($urandom % 4);
      busyLen = 8'($urandom % 12);
      gap = 1 + int'($urandom % 4);
      repeat (1 + int'($urandom % 20)) tickGap();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule